// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources into two request outputs. One output is meant for the processor's normal interrupt input and the other for its fast interrupt input. A single raw level vector is shared by both outputs. Each output has its own enable mask, and it rises when any raw bit that its mask enables is high. The controller does not prioritise, vector or detect edges. It only combines levels.

Software reaches the block through a simple 32-bit register bus with word addresses. Enable bits are never written directly. Separate set and clear addresses each change only the bits written as one, so two agents can update masks without a read-modify-write. Source 0 can also be raised from software. A stored soft bit is ORed with external input 0. Both outputs pass through one register, so they follow a change of a level or a mask one clock later.

Top module: `dual_lvl_intc`

## Requirements
- R1: After reset both enable masks and the soft bit are zero, irq_out and fiq_out are low, and the enable words (2, 10) and word 4 read zero.
- R2: Word 1 and word 9 both read the raw level vector. Its bit 0 is the OR of src_lvl[0] and the soft bit, and its other bits equal src_lvl.
- R3: irq_out equals, one clock later, the OR over all bits of (raw AND IRQ enable). It does not change in the cycle of the input change.
- R4: fiq_out equals, one clock later, the OR over all bits of (raw AND FIQ enable).
- R5: Writing word 2 ORs the write data into the IRQ enable mask. Writing word 3 clears the mask bits written as one. Word 2 reads the mask.
- R6: Writing word 10 ORs the write data into the FIQ enable mask. Writing word 11 clears the bits written as one. Word 10 reads the mask.
- R7: Word 0 reads raw AND IRQ enable. Word 8 reads raw AND FIQ enable.
- R8: Writing word 4 with data bit 0 = 1 sets the soft bit, and writing word 5 with bit 0 = 1 clears it. With bit 0 = 0 either write has no effect. Word 4 reads raw bit 0 in bit 0, with zeros above.
- R9: Reads of the write-only words 3, 5 and 11, and of unmapped words (6, 7, 12 to 15), return zero.
- R10: Writes to the status words 0, 1, 8 and 9 leave both enable masks and the soft bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | NUM_SRC | Interrupt source levels, active high |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq_out | output | 1 | Registered normal interrupt request |
| fiq_out | output | 1 | Registered fast interrupt request |

## Verification
The hardest case to reach from the ports is bit 0 of the raw vector. It can be driven by the pin, by the stored soft bit, or by both, and a wrong merge only shows when the two disagree. The stimulus first clears every source. It then sets the soft bit with writes whose bit 0 is zero and later one, and it also writes to the clear word with bit 0 zero. After each step it reads words 1 and 4 and watches irq_out with only bit 0 enabled. It then drives src_lvl[0] alone with the soft bit cleared, which confirms that the OR and not the soft bit alone sets the raw bit.

// File: rtl/dli_pkg.sv
package dli_pkg;
   // Word addresses. The bus decodes them, so their values are fixed.
   localparam int unsigned A_IRQ_MASKED = 0;
   localparam int unsigned A_IRQ_RAW    = 1;
   localparam int unsigned A_IRQ_EN_SET = 2;
   localparam int unsigned A_IRQ_EN_CLR = 3;
   localparam int unsigned A_SOFT_SET   = 4;
   localparam int unsigned A_SOFT_CLR   = 5;
   localparam int unsigned A_FIQ_MASKED = 8;
   localparam int unsigned A_FIQ_RAW    = 9;
   localparam int unsigned A_FIQ_EN_SET = 10;
   localparam int unsigned A_FIQ_EN_CLR = 11;

   // Channel indices into the per-output arrays.
   localparam int unsigned CH_IRQ = 0;
   localparam int unsigned CH_FIQ = 1;
   localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/dli_wr_decode.sv
module dli_wr_decode
   import dli_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              wdata_b0,
   output logic [NUM_CH-1:0] en_set,
   output logic [NUM_CH-1:0] en_clr,
   output logic              soft_set,
   output logic              soft_clr
);
   always_comb begin
      en_set   = '0;
      en_clr   = '0;
      soft_set = 1'b0;
      soft_clr = 1'b0;
      if (bus_wr) begin
         case (bus_addr)
            ADDR_W'(A_IRQ_EN_SET): en_set[CH_IRQ] = 1'b1;
            ADDR_W'(A_IRQ_EN_CLR): en_clr[CH_IRQ] = 1'b1;
            ADDR_W'(A_FIQ_EN_SET): en_set[CH_FIQ] = 1'b1;
            ADDR_W'(A_FIQ_EN_CLR): en_clr[CH_FIQ] = 1'b1;
            ADDR_W'(A_SOFT_SET):   soft_set = wdata_b0;
            ADDR_W'(A_SOFT_CLR):   soft_clr = wdata_b0;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dli_channel.sv
module dli_channel #(
   parameter int unsigned NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_stb,
   input  logic               clr_stb,
   input  logic [NUM_SRC-1:0] wbits,
   input  logic [NUM_SRC-1:0] raw,
   output logic [NUM_SRC-1:0] en_q,
   output logic               req_q
);
   // The enable mask changes only through write-one-to-set and write-one-to-clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (set_stb) begin
         en_q <= en_q | wbits;
      end else if (clr_stb) begin
         en_q <= en_q & ~wbits;
      end
   end

   // A single register stage on the request output.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else begin
         req_q <= |(raw & en_q);
      end
   end
endmodule

// File: rtl/dli_read_mux.sv
module dli_read_mux
   import dli_pkg::*;
#(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4
) (
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [NUM_SRC-1:0] raw,
   input  logic [NUM_SRC-1:0] irq_en,
   input  logic [NUM_SRC-1:0] fiq_en,
   output logic [DATA_W-1:0]  rdata
);
   logic [NUM_SRC-1:0] sel;

   always_comb begin
      case (bus_addr)
         ADDR_W'(A_IRQ_MASKED): sel = raw & irq_en;
         ADDR_W'(A_IRQ_RAW):    sel = raw;
         ADDR_W'(A_IRQ_EN_SET): sel = irq_en;
         ADDR_W'(A_SOFT_SET):   sel = {{(NUM_SRC-1){1'b0}}, raw[0]};
         ADDR_W'(A_FIQ_MASKED): sel = raw & fiq_en;
         ADDR_W'(A_FIQ_RAW):    sel = raw;
         ADDR_W'(A_FIQ_EN_SET): sel = fiq_en;
         default:               sel = '0;
      endcase
      rdata              = '0;
      rdata[NUM_SRC-1:0] = sel;
   end
endmodule

// File: rtl/dual_lvl_intc.sv
module dual_lvl_intc
   import dli_pkg::*;
#(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_lvl,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_out,
   output logic               fiq_out
);
   localparam int unsigned MIN_ADDR_W = $clog2(A_FIQ_EN_CLR + 1);

   if (NUM_SRC < 2 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("dual_lvl_intc: NUM_SRC must lie in 2..DATA_W");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("dual_lvl_intc: ADDR_W too narrow for the register words");
   end

   logic [NUM_CH-1:0]              en_set;
   logic [NUM_CH-1:0]              en_clr;
   logic                           soft_set;
   logic                           soft_clr;
   logic                           soft_q;
   logic [NUM_SRC-1:0]             raw_lvl;
   logic [NUM_CH-1:0][NUM_SRC-1:0] chan_en;
   logic [NUM_CH-1:0]              chan_req;
   logic [NUM_SRC-1:0]             irq_en;
   logic [NUM_SRC-1:0]             fiq_en;

   dli_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .wdata_b0 (bus_wdata[0]),
      .en_set   (en_set),
      .en_clr   (en_clr),
      .soft_set (soft_set),
      .soft_clr (soft_clr)
   );

   // Software-raised level on source 0.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_q <= 1'b0;
      end else if (soft_set) begin
         soft_q <= 1'b1;
      end else if (soft_clr) begin
         soft_q <= 1'b0;
      end
   end

   always_comb begin
      raw_lvl    = src_lvl;
      raw_lvl[0] = src_lvl[0] | soft_q;
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      dli_channel #(.NUM_SRC(NUM_SRC)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_stb (en_set[ch]),
         .clr_stb (en_clr[ch]),
         .wbits   (bus_wdata[NUM_SRC-1:0]),
         .raw     (raw_lvl),
         .en_q    (chan_en[ch]),
         .req_q   (chan_req[ch])
      );
   end

   assign irq_en  = chan_en[CH_IRQ];
   assign fiq_en  = chan_en[CH_FIQ];
   assign irq_out = chan_req[CH_IRQ];
   assign fiq_out = chan_req[CH_FIQ];

   dli_read_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
      .bus_addr (bus_addr),
      .raw      (raw_lvl),
      .irq_en   (irq_en),
      .fiq_en   (fiq_en),
      .rdata    (bus_rdata)
   );
endmodule

// File: rtl/dli_intc_chk.sv
module dli_intc_chk
   import dli_pkg::*;
#(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [NUM_SRC-1:0] raw_lvl,
   input logic [NUM_SRC-1:0] irq_en,
   input logic [NUM_SRC-1:0] fiq_en,
   input logic               soft_q,
   input logic               irq_out,
   input logic               fiq_out
);
   logic [NUM_SRC-1:0] wbits;
   logic               wr_status;
   assign wbits     = bus_wdata[NUM_SRC-1:0];
   assign wr_status = bus_wr && (bus_addr == ADDR_W'(A_IRQ_MASKED) || bus_addr == ADDR_W'(A_IRQ_RAW) ||
                                 bus_addr == ADDR_W'(A_FIQ_MASKED) || bus_addr == ADDR_W'(A_FIQ_RAW));

   AST_IRQ_LAGS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == $past(|(raw_lvl & irq_en))); // R3
   AST_FIQ_LAGS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_out == $past(|(raw_lvl & fiq_en))); // R4
   AST_IRQ_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(A_IRQ_EN_SET) |=> (irq_en & $past(wbits)) == $past(wbits)); // R5
   AST_IRQ_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(A_IRQ_EN_CLR) |=> (irq_en & $past(wbits)) == '0); // R5
   AST_FIQ_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(A_FIQ_EN_SET) |=> (fiq_en & $past(wbits)) == $past(wbits)); // R6
   AST_FIQ_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(A_FIQ_EN_CLR) |=> (fiq_en & $past(wbits)) == '0); // R6
   AST_SOFT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(A_SOFT_SET) && bus_wdata[0] |=> soft_q); // R8
   AST_SOFT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(A_SOFT_CLR) && bus_wdata[0] |=> !soft_q); // R8
   AST_SOFT_B0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && (bus_addr == ADDR_W'(A_SOFT_SET) || bus_addr == ADDR_W'(A_SOFT_CLR)) && !bus_wdata[0]
      |=> $stable(soft_q)); // R8
   AST_STATUS_WR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_status |=> $stable(irq_en) && $stable(fiq_en) && $stable(soft_q)); // R10
endmodule

bind dual_lvl_intc dli_intc_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .raw_lvl   (raw_lvl),
   .irq_en    (irq_en),
   .fiq_en    (fiq_en),
   .soft_q    (soft_q),
   .irq_out   (irq_out),
   .fiq_out   (fiq_out)
);

// File: tb/test_dual_lvl_intc.sv
`timescale 1ns/1ps
module test_dual_lvl_intc;
   localparam int NS = 32;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_lvl = '0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq_out;
   logic          fiq_out;

   always #4 clk = ~clk;

   dual_lvl_intc #(.NUM_SRC(NS), .DATA_W(32), .ADDR_W(AW)) i_dual_lvl_intc (
      .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out), .fiq_out(fiq_out));

   typedef struct {
      int          kind;   // 0 read data, 1 irq_out, 2 fiq_out
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   // Reference model, written from the requirements.
   logic [31:0] m_irq = '0, m_fiq = '0;
   logic        m_soft = 1'b0;

   function automatic logic [31:0] m_raw();
      return src_lvl | {31'd0, m_soft};
   endfunction

   // Monitor: compares queued expectations away from the clock edge.
   initial begin
      forever begin
         @(negedge clk);
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? {31'd0, irq_out} : {31'd0, fiq_out};
            n_chk++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: kind %0d actual %h expected %h", it.tag, it.kind, act, it.exp);
            end
         end
      end
   end

   task automatic push(int kind, logic [31:0] exp, string tag);
      item_t it;
      it.kind = kind; it.exp = exp; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic rd(int a, logic [31:0] exp, string tag);
      @(posedge clk); #1;
      bus_addr = AW'(a);
      push(0, exp, tag);
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
      case (a)
         2:  m_irq = m_irq | d;
         3:  m_irq = m_irq & ~d;
         10: m_fiq = m_fiq | d;
         11: m_fiq = m_fiq & ~d;
         4:  if (d[0]) m_soft = 1'b1;
         5:  if (d[0]) m_soft = 1'b0;
         default: ;
      endcase
   endtask

   // Outputs after one more edge so the registered stage has caught up.
   task automatic outs(string tag);
      @(posedge clk); #1;
      push(1, {31'd0, |(m_raw() & m_irq)}, tag);
      push(2, {31'd0, |(m_raw() & m_fiq)}, tag);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      push(1, 32'd0, "R1"); push(2, 32'd0, "R1");
      rd(2, 32'd0, "R1"); rd(10, 32'd0, "R1"); rd(4, 32'd0, "R1"); rd(0, 32'd0, "R1");
      // R2 raw view on both words
      @(posedge clk); #1 src_lvl = 32'h8000_0011;
      rd(1, m_raw(), "R2"); rd(9, m_raw(), "R2");
      outs("R3 nothing enabled");
      // R5 set, OR accumulate, read back; R3 output; R7 masked view
      wr(2, 32'h0000_0010);
      outs("R3 after enable");
      rd(2, 32'h0000_0010, "R5"); rd(0, 32'h0000_0010, "R7");
      wr(2, 32'h0000_0100);
      rd(2, 32'h0000_0110, "R5 or");
      wr(3, 32'h0000_0010);
      rd(2, 32'h0000_0100, "R5 clear");
      outs("R3 after clear");
      // R3 one-clock lag: output keeps old value in the cycle of the input change
      @(posedge clk); #1 src_lvl = 32'h8000_0111;
      push(1, 32'd0, "R3 lag");
      outs("R3 follows");
      // R6 / R4 / R7
      wr(10, 32'hFFFF_0000);
      outs("R4 set");
      rd(8, 32'h8000_0000, "R7 fiq");
      wr(11, 32'h8000_0000);
      rd(10, 32'h7FFF_0000, "R6 clear");
      outs("R4 cleared");
      // R8 soft line on bit 0
      wr(3, 32'hFFFF_FFFF);
      @(posedge clk); #1 src_lvl = '0;
      wr(2, 32'h0000_0001);
      wr(4, 32'hFFFF_FFFE);
      rd(4, 32'd0, "R8 bit0 only"); rd(1, 32'd0, "R8 bit0 only");
      wr(4, 32'h0000_0001);
      rd(1, 32'h0000_0001, "R8 set"); rd(4, 32'h0000_0001, "R8 set");
      outs("R8 soft to irq");
      wr(5, 32'hFFFF_FFFE);
      rd(4, 32'h0000_0001, "R8 clear ignored");
      wr(5, 32'h0000_0001);
      rd(4, 32'd0, "R8 clear");
      outs("R8 soft gone");
      @(posedge clk); #1 src_lvl = 32'h0000_0001;
      rd(4, 32'h0000_0001, "R2 pin bit0");
      outs("R2 pin bit0");
      // R9 write-only and unmapped words
      wr(10, 32'h0000_00F0);
      rd(3, 32'd0, "R9"); rd(5, 32'd0, "R9"); rd(11, 32'd0, "R9");
      rd(6, 32'd0, "R9"); rd(15, 32'd0, "R9");
      // R10 writes to status words
      wr(4, 32'h0000_0001);
      wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF); wr(8, 32'hFFFF_FFFF); wr(9, 32'hFFFF_FFFF);
      rd(2, m_irq, "R10"); rd(10, m_fiq, "R10");
      @(posedge clk); #1 src_lvl = '0;
      rd(4, 32'h0000_0001, "R10 soft kept");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule